// File: doc/BRIEF.md
# Per-Port Class Queue Manager

This block keeps the transmit queues of a multi-port frame switch. Each forwarding decision brings a frame handle, a class and either one destination port (unicast) or a mask of destination ports (multicast). A unicast frame is either dropped, with its handle handed back for release, or appended to the linked list for its port and class. The list is threaded through a next-pointer store indexed by handle, with head, tail and length registers per list. A multicast frame is copied into a small physical FIFO on each destination port. There is one such FIFO for each pair of classes, and the FIFO for a class is found at index class>>1.

When a transmit port asks for its next frame, the block looks only at that port's queues. For each class it merges the unicast list with the multicast FIFO head whose stored class equals that class, giving one logical queue. The highest-index non-empty class wins. Inside a class, unicast and multicast heads take turns when both are waiting. The block answers one cycle after the request with a handle or a not-valid response. A free-buffer count input drives the global drop decision. Frame data is not moved here.

Top module: `class_queue_mgr`

## Requirements
- R1: After reset every queue is empty: a request to any port gives deq_valid=0, and rel_valid is 0.
- R2: An accepted unicast frame is appended to the list of (enq_port, enq_class). Requests to that port return its handles in arrival order with deq_mcast=0. The response appears in the cycle after deq_req.
- R3: A unicast frame whose list already holds UC_LIMIT entries is not linked. Its handle appears on rel_handle with rel_valid=1 in the cycle after enq_valid.
- R4: When free_cnt < FREE_MIN, any arriving frame, unicast or multicast, is dropped everywhere and released in the next cycle. At free_cnt = FREE_MIN the frame is accepted.
- R5: A multicast frame is pushed into FIFO index enq_class>>1 of every port whose bit is set in enq_pmask. Each of those ports later returns the handle with deq_mcast=1 and deq_class=enq_class. Other ports do not receive it.
- R6: A port whose target multicast FIFO already holds MC_DEPTH entries is skipped. The handle is released only if no destination port accepted it.
- R7: Among a port's classes, the non-empty logical queue with the highest class index is served first.
- R8: A multicast FIFO head counts toward class c only when its stored class equals c. A FIFO shared by two classes delivers its entries in push order.
- R9: When the unicast list and the matching multicast head of a class are both present, the source not served last time in that class is served. The first such tie after reset serves unicast.
- R10: A request to a port with no queued frame returns deq_valid=0 and changes no queue.
- R11: An append and a pop on the same unicast list in one cycle are both applied, including when the list held one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| free_cnt | input | FREE_W | Count of free frame buffers |
| enq_valid | input | 1 | Forwarding decision present |
| enq_mcast | input | 1 | 1 = multicast (uses enq_pmask), 0 = unicast (uses enq_port) |
| enq_handle | input | $clog2(NHANDLES) | Frame handle |
| enq_port | input | $clog2(NPORTS) | Unicast destination port |
| enq_class | input | $clog2(NCLASS) | Transmission class, higher is more urgent |
| enq_pmask | input | NPORTS | Multicast destination ports, bit p = port p |
| deq_req | input | 1 | Port asks for its next frame |
| deq_port | input | $clog2(NPORTS) | Requesting port |
| deq_valid | output | 1 | Response carries a frame |
| deq_handle | output | $clog2(NHANDLES) | Handle of the chosen frame |
| deq_mcast | output | 1 | Chosen frame came from a multicast FIFO |
| deq_class | output | $clog2(NCLASS) | Class of the chosen frame |
| rel_valid | output | 1 | A dropped handle is to be released |
| rel_handle | output | $clog2(NHANDLES) | Handle to release |

## Verification
Unicast runs into a single list check arrival order. Frames spread over several classes on one port separate strict priority from arrival order. Filling one list to its limit, and starving the free count just below and at the threshold, separate the local drop from the global drop. Multicast frames with masks that hit full and non-full FIFOs separate a selective drop from a full release. A class holding both unicast and multicast heads, with a shared FIFO holding entries of two classes, exposes the alternation and the class-match merge. An append and a pop on a one-entry list in the same cycle tests the head bypass.

// File: rtl/cqm_pkg.sv
package cqm_pkg;
    localparam int QM_PORTS    = 4;
    localparam int QM_CLASSES  = 8;
    localparam int QM_HANDLES  = 64;
    localparam int QM_MC_DEPTH = 4;
    localparam int QM_UC_LIMIT = 6;
    localparam int QM_FREE_MIN = 4;
    localparam int QM_FREE_W   = 8;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_UC   = 2'd1,
        SRC_MC   = 2'd2
    } src_e;

    function automatic int pair_of(input int cls);
        return cls / 2;
    endfunction
endpackage

// File: rtl/cqm_uc_lists.sv
module cqm_uc_lists #(
    parameter int NQ    = 32,
    parameter int NH    = 64,
    parameter int LIMIT = 6,
    localparam int HW   = $clog2(NH),
    localparam int QW   = $clog2(NQ),
    localparam int LW   = $clog2(LIMIT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   app_en,
    input  logic [QW-1:0]          app_q,
    input  logic [HW-1:0]          app_h,
    input  logic                   pop_en,
    input  logic [QW-1:0]          pop_q,
    output logic [NQ-1:0][LW-1:0]  len,
    output logic [NQ-1:0][HW-1:0]  head
);
    logic [NQ-1:0][HW-1:0] tail;
    logic [HW-1:0]         nxt [NH];
    logic [NQ-1:0]         app_hit, pop_hit;

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            app_hit[q] = app_en && (app_q == QW'(q));
            pop_hit[q] = pop_en && (pop_q == QW'(q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NQ; q++) begin
                len[q]  <= '0;
                head[q] <= '0;
                tail[q] <= '0;
            end
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (app_hit[q] && (len[q] == '0 || (pop_hit[q] && len[q] == LW'(1))))
                    head[q] <= app_h;
                else if (pop_hit[q])
                    head[q] <= nxt[head[q]];
                if (app_hit[q])
                    tail[q] <= app_h;
                len[q] <= len[q] + LW'(app_hit[q]) - LW'(pop_hit[q]);
            end
        end
    end

    // link the new handle behind the current tail of a non-empty list
    always_ff @(posedge clk) begin
        if (app_en && len[app_q] != '0)
            nxt[tail[app_q]] <= app_h;
    end
endmodule

// File: rtl/cqm_mc_fifo.sv
module cqm_mc_fifo #(
    parameter int DEPTH = 4,
    parameter int HW    = 6,
    parameter int CW    = 3,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [HW-1:0] din_h,
    input  logic [CW-1:0] din_c,
    input  logic          pop,
    output logic [HW-1:0] head_h,
    output logic [CW-1:0] head_c,
    output logic [DW-1:0] cnt,
    output logic          full
);
    logic [HW-1:0] mem_h [DEPTH];
    logic [CW-1:0] mem_c [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (cnt == DW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (cnt != '0);
    assign head_h  = mem_h[rp];
    assign head_c  = mem_c[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + DW'(do_push) - DW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_h[wp] <= din_h;
            mem_c[wp] <= din_c;
        end
    end
endmodule

// File: rtl/cqm_sched.sv
module cqm_sched
    import cqm_pkg::*;
#(
    parameter int NCLASS = 8,
    localparam int CW    = $clog2(NCLASS)
) (
    input  logic [NCLASS-1:0] uc_nz,
    input  logic [NCLASS-1:0] mc_hit,
    input  logic [NCLASS-1:0] last_mc,
    output src_e              src,
    output logic [CW-1:0]     cls
);
    always_comb begin
        src = SRC_NONE;
        cls = '0;
        // ascending scan: the highest non-empty class is kept
        for (int c = 0; c < NCLASS; c++) begin
            if (uc_nz[c] || mc_hit[c]) begin
                cls = CW'(c);
                if (mc_hit[c] && (!uc_nz[c] || !last_mc[c]))
                    src = SRC_MC;
                else
                    src = SRC_UC;
            end
        end
    end
endmodule

// File: rtl/class_queue_mgr.sv
module class_queue_mgr
    import cqm_pkg::*;
#(
    parameter int NPORTS   = QM_PORTS,
    parameter int NCLASS   = QM_CLASSES,
    parameter int NHANDLES = QM_HANDLES,
    parameter int MC_DEPTH = QM_MC_DEPTH,
    parameter int UC_LIMIT = QM_UC_LIMIT,
    parameter int FREE_MIN = QM_FREE_MIN,
    parameter int FREE_W   = QM_FREE_W,
    localparam int PW      = $clog2(NPORTS),
    localparam int CW      = $clog2(NCLASS),
    localparam int HW      = $clog2(NHANDLES),
    localparam int NPAIR   = NCLASS / 2,
    localparam int NQ      = NPORTS * NCLASS,
    localparam int QW      = $clog2(NQ),
    localparam int LW      = $clog2(UC_LIMIT + 1),
    localparam int DW      = $clog2(MC_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic              enq_valid,
    input  logic              enq_mcast,
    input  logic [HW-1:0]     enq_handle,
    input  logic [PW-1:0]     enq_port,
    input  logic [CW-1:0]     enq_class,
    input  logic [NPORTS-1:0] enq_pmask,
    input  logic              deq_req,
    input  logic [PW-1:0]     deq_port,
    output logic              deq_valid,
    output logic [HW-1:0]     deq_handle,
    output logic              deq_mcast,
    output logic [CW-1:0]     deq_class,
    output logic              rel_valid,
    output logic [HW-1:0]     rel_handle
);
    // ---------------- state views ----------------
    logic [NQ-1:0][LW-1:0]                 uc_len;
    logic [NQ-1:0][HW-1:0]                 uc_head;
    logic [NPORTS-1:0][NPAIR-1:0][HW-1:0]  mc_hh;
    logic [NPORTS-1:0][NPAIR-1:0][CW-1:0]  mc_hc;
    logic [NPORTS-1:0][NPAIR-1:0][DW-1:0]  mc_cnt;
    logic [NPORTS-1:0][NPAIR-1:0]          mc_full;
    logic [NPORTS-1:0][NPAIR-1:0]          mc_push, mc_pop;
    logic [NQ-1:0]                         last_mc_r;

    // ---------------- admission ----------------
    logic          glob_ok, uc_accept, mc_any, drop_all;
    logic [QW-1:0] enq_q;
    logic [CW-2:0] enq_pair;

    assign glob_ok   = (free_cnt >= FREE_W'(FREE_MIN));
    assign enq_q     = QW'(enq_port) * QW'(NCLASS) + QW'(enq_class);
    assign enq_pair  = enq_class[CW-1:1];
    assign uc_accept = enq_valid && !enq_mcast && glob_ok
                       && (uc_len[enq_q] < LW'(UC_LIMIT));
    assign mc_any    = |mc_push;
    assign drop_all  = enq_valid && (enq_mcast ? !mc_any : !uc_accept);

    // ---------------- scheduling for the requesting port ----------------
    logic [NCLASS-1:0] sel_uc_nz, sel_mc_hit, sel_last_mc;
    src_e              pick_src;
    logic [CW-1:0]     pick_cls;
    logic [QW-1:0]     pick_q;
    logic              pop_uc, pop_any;
    logic [HW-1:0]     pick_h;

    always_comb begin
        for (int c = 0; c < NCLASS; c++) begin
            sel_uc_nz[c]   = uc_len[QW'(deq_port) * QW'(NCLASS) + QW'(c)] != '0;
            sel_mc_hit[c]  = (mc_cnt[deq_port][pair_of(c)] != '0)
                             && (mc_hc[deq_port][pair_of(c)] == CW'(c));
            sel_last_mc[c] = last_mc_r[QW'(deq_port) * QW'(NCLASS) + QW'(c)];
        end
    end

    cqm_sched #(.NCLASS(NCLASS)) sched_i (
        .uc_nz   (sel_uc_nz),
        .mc_hit  (sel_mc_hit),
        .last_mc (sel_last_mc),
        .src     (pick_src),
        .cls     (pick_cls)
    );

    assign pick_q  = QW'(deq_port) * QW'(NCLASS) + QW'(pick_cls);
    assign pop_any = deq_req && (pick_src != SRC_NONE);
    assign pop_uc  = deq_req && (pick_src == SRC_UC);
    assign pick_h  = (pick_src == SRC_MC) ? mc_hh[deq_port][pick_cls[CW-1:1]]
                                          : uc_head[pick_q];

    // ---------------- storage ----------------
    cqm_uc_lists #(.NQ(NQ), .NH(NHANDLES), .LIMIT(UC_LIMIT)) lists_i (
        .clk    (clk),
        .rst    (rst),
        .app_en (uc_accept),
        .app_q  (enq_q),
        .app_h  (enq_handle),
        .pop_en (pop_uc),
        .pop_q  (pick_q),
        .len    (uc_len),
        .head   (uc_head)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        for (genvar k = 0; k < NPAIR; k++) begin : g_pair
            assign mc_push[p][k] = enq_valid && enq_mcast && glob_ok && enq_pmask[p]
                                   && (enq_pair == (CW-1)'(k)) && !mc_full[p][k];
            assign mc_pop[p][k]  = deq_req && (pick_src == SRC_MC)
                                   && (deq_port == PW'(p))
                                   && (pick_cls[CW-1:1] == (CW-1)'(k));
            cqm_mc_fifo #(.DEPTH(MC_DEPTH), .HW(HW), .CW(CW)) fifo_i (
                .clk    (clk),
                .rst    (rst),
                .push   (mc_push[p][k]),
                .din_h  (enq_handle),
                .din_c  (enq_class),
                .pop    (mc_pop[p][k]),
                .head_h (mc_hh[p][k]),
                .head_c (mc_hc[p][k]),
                .cnt    (mc_cnt[p][k]),
                .full   (mc_full[p][k])
            );
        end
    end

    // ---------------- registered responses ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            deq_valid  <= 1'b0;
            deq_handle <= '0;
            deq_mcast  <= 1'b0;
            deq_class  <= '0;
            rel_valid  <= 1'b0;
            rel_handle <= '0;
            last_mc_r  <= '1;
        end else begin
            deq_valid <= pop_any;
            if (pop_any) begin
                deq_handle        <= pick_h;
                deq_mcast         <= (pick_src == SRC_MC);
                deq_class         <= pick_cls;
                last_mc_r[pick_q] <= (pick_src == SRC_MC);
            end
            rel_valid <= drop_all;
            if (drop_all) rel_handle <= enq_handle;
        end
    end
endmodule

// File: rtl/class_queue_mgr_chk.sv
module class_queue_mgr_chk #(
    parameter int NQ       = 32,
    parameter int NFIFO    = 16,
    parameter int LW       = 3,
    parameter int DW       = 3,
    parameter int HW       = 6,
    parameter int FREE_W   = 8,
    parameter int UC_LIMIT = 6,
    parameter int MC_DEPTH = 4,
    parameter int FREE_MIN = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  enq_valid,
    input logic [HW-1:0]         enq_handle,
    input logic [FREE_W-1:0]     free_cnt,
    input logic                  deq_req,
    input logic                  deq_valid,
    input logic                  rel_valid,
    input logic [HW-1:0]         rel_handle,
    input logic [NQ*LW-1:0]      uc_len_all,
    input logic [NFIFO*DW-1:0]   mc_cnt_all
);
    // R2: a response only follows a request
    assert_deq_after_req_R2: assert property (@(posedge clk) disable iff (rst)
        deq_valid |-> $past(deq_req));

    // R3: a release only follows an arriving frame
    assert_rel_after_enq_R3: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> $past(enq_valid));

    // R4: starved buffer pool releases the frame next cycle
    assert_global_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && free_cnt < FREE_W'(FREE_MIN))
        |=> (rel_valid && rel_handle == $past(enq_handle)));

    for (genvar q = 0; q < NQ; q++) begin : g_len
        // R3: no list grows past its limit
        assert_uc_limit_R3: assert property (@(posedge clk) disable iff (rst)
            uc_len_all[q*LW +: LW] <= LW'(UC_LIMIT));
    end

    for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
        // R6: no multicast FIFO overflows
        assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
            mc_cnt_all[f*DW +: DW] <= DW'(MC_DEPTH));
    end
endmodule

bind class_queue_mgr class_queue_mgr_chk #(
    .NQ(NQ), .NFIFO(NPORTS * NPAIR), .LW(LW), .DW(DW), .HW(HW),
    .FREE_W(FREE_W), .UC_LIMIT(UC_LIMIT), .MC_DEPTH(MC_DEPTH), .FREE_MIN(FREE_MIN)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .enq_valid  (enq_valid),
    .enq_handle (enq_handle),
    .free_cnt   (free_cnt),
    .deq_req    (deq_req),
    .deq_valid  (deq_valid),
    .rel_valid  (rel_valid),
    .rel_handle (rel_handle),
    .uc_len_all (uc_len),
    .mc_cnt_all (mc_cnt)
);

// File: tb/class_queue_mgr_tb_top.sv
module class_queue_mgr_tb_top;
    localparam int NP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] free_cnt = 8'd100;
    logic       enq_valid = 1'b0, enq_mcast = 1'b0;
    logic [5:0] enq_handle = '0;
    logic [1:0] enq_port = '0;
    logic [2:0] enq_class = '0;
    logic [3:0] enq_pmask = '0;
    logic       deq_req = 1'b0;
    logic [1:0] deq_port = '0;
    logic       deq_valid, deq_mcast, rel_valid;
    logic [5:0] deq_handle, rel_handle;
    logic [2:0] deq_class;

    int total = 0;
    int bad   = 0;
    int g_rv, g_rh, g_dv, g_dh, g_dm, g_dc;

    always #2.5 clk = ~clk;

    class_queue_mgr dut_i (
        .clk(clk), .rst(rst), .free_cnt(free_cnt),
        .enq_valid(enq_valid), .enq_mcast(enq_mcast), .enq_handle(enq_handle),
        .enq_port(enq_port), .enq_class(enq_class), .enq_pmask(enq_pmask),
        .deq_req(deq_req), .deq_port(deq_port),
        .deq_valid(deq_valid), .deq_handle(deq_handle), .deq_mcast(deq_mcast),
        .deq_class(deq_class), .rel_valid(rel_valid), .rel_handle(rel_handle)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic capture();
        g_rv = rel_valid;  g_rh = rel_handle;
        g_dv = deq_valid;  g_dh = deq_handle;
        g_dm = deq_mcast;  g_dc = deq_class;
    endtask

    task automatic enq(input bit mc, input int h, input int p, input int c, input int mask);
        @(negedge clk);
        enq_valid = 1'b1; enq_mcast = mc; enq_handle = 6'(h);
        enq_port = 2'(p); enq_class = 3'(c); enq_pmask = 4'(mask);
        @(negedge clk);
        enq_valid = 1'b0;
        capture();
    endtask

    task automatic deq(input int p);
        @(negedge clk);
        deq_req = 1'b1; deq_port = 2'(p);
        @(negedge clk);
        deq_req = 1'b0;
        capture();
    endtask

    task automatic expect_frame(input string req, input int p, input int h, input int mc, input int c);
        deq(p);
        chk(req, "deq_valid", g_dv, 1);
        chk(req, "deq_handle", g_dh, h);
        chk(req, "deq_mcast", g_dm, mc);
        chk(req, "deq_class", g_dc, c);
    endtask

    task automatic expect_empty(input string req, input int p);
        deq(p);
        chk(req, "empty deq_valid", g_dv, 0);
    endtask

    task automatic t_reset();
        for (int p = 0; p < NP; p++) expect_empty("R1", p);
        chk("R1", "rel_valid", g_rv, 0);
    endtask

    task automatic t_uc_order();
        for (int h = 5; h <= 7; h++) begin
            enq(1'b0, h, 1, 2, 0);
            chk("R2", "no release", g_rv, 0);
        end
        for (int h = 5; h <= 7; h++) expect_frame("R2", 1, h, 0, 2);
        expect_empty("R10", 1);
    endtask

    task automatic t_priority();
        enq(1'b0, 10, 0, 1, 0);
        enq(1'b0, 11, 0, 6, 0);
        enq(1'b0, 12, 0, 3, 0);
        expect_frame("R7", 0, 11, 0, 6);
        expect_frame("R7", 0, 12, 0, 3);
        expect_frame("R7", 0, 10, 0, 1);
    endtask

    task automatic t_limit();
        for (int h = 20; h <= 25; h++) enq(1'b0, h, 2, 0, 0);
        chk("R3", "last accepted no release", g_rv, 0);
        enq(1'b0, 26, 2, 0, 0);
        chk("R3", "over-limit rel_valid", g_rv, 1);
        chk("R3", "over-limit rel_handle", g_rh, 26);
        for (int h = 20; h <= 25; h++) expect_frame("R3", 2, h, 0, 0);
        expect_empty("R3", 2);
    endtask

    task automatic t_global();
        free_cnt = 8'd3;
        enq(1'b0, 30, 0, 0, 0);
        chk("R4", "uc rel_valid", g_rv, 1);
        chk("R4", "uc rel_handle", g_rh, 30);
        enq(1'b1, 31, 0, 0, 1);
        chk("R4", "mc rel_valid", g_rv, 1);
        chk("R4", "mc rel_handle", g_rh, 31);
        expect_empty("R4", 0);
        free_cnt = 8'd4;
        enq(1'b0, 30, 0, 0, 0);
        chk("R4", "at threshold no release", g_rv, 0);
        expect_frame("R4", 0, 30, 0, 0);
        free_cnt = 8'd100;
    endtask

    task automatic t_mcast();
        enq(1'b1, 40, 0, 5, 4'b1010);
        chk("R5", "no release", g_rv, 0);
        expect_frame("R5", 1, 40, 1, 5);
        expect_frame("R5", 3, 40, 1, 5);
        expect_empty("R5", 0);
        expect_empty("R5", 2);
    endtask

    task automatic t_alternate();
        enq(1'b0, 41, 0, 4, 0);
        enq(1'b0, 42, 0, 4, 0);
        enq(1'b1, 43, 0, 4, 4'b0001);
        enq(1'b1, 44, 0, 4, 4'b0001);
        expect_frame("R9", 0, 41, 0, 4);
        expect_frame("R9", 0, 43, 1, 4);
        expect_frame("R9", 0, 42, 0, 4);
        expect_frame("R9", 0, 44, 1, 4);
        expect_empty("R9", 0);
    endtask

    task automatic t_shared();
        enq(1'b1, 45, 0, 5, 4'b0001);
        enq(1'b1, 46, 0, 4, 4'b0001);
        enq(1'b0, 47, 0, 4, 0);
        expect_frame("R8", 0, 45, 1, 5);
        expect_frame("R8", 0, 47, 0, 4);
        expect_frame("R8", 0, 46, 1, 4);
        expect_empty("R8", 0);
    endtask

    task automatic t_mc_full();
        for (int h = 60; h <= 63; h++) enq(1'b1, h, 0, 0, 4'b0100);
        enq(1'b1, 59, 0, 0, 4'b0100);
        chk("R6", "all full rel_valid", g_rv, 1);
        chk("R6", "all full rel_handle", g_rh, 59);
        enq(1'b1, 58, 0, 1, 4'b1100);
        chk("R6", "partial no release", g_rv, 0);
        expect_frame("R6", 3, 58, 1, 1);
        expect_empty("R6", 3);
        for (int h = 60; h <= 63; h++) expect_frame("R6", 2, h, 1, 0);
        expect_empty("R6", 2);
    endtask

    task automatic t_bypass();
        enq(1'b0, 50, 3, 7, 0);
        @(negedge clk);
        enq_valid = 1'b1; enq_mcast = 1'b0; enq_handle = 6'd51;
        enq_port = 2'd3; enq_class = 3'd7;
        deq_req = 1'b1; deq_port = 2'd3;
        @(negedge clk);
        enq_valid = 1'b0; deq_req = 1'b0;
        capture();
        chk("R11", "same-cycle deq_valid", g_dv, 1);
        chk("R11", "same-cycle deq_handle", g_dh, 50);
        chk("R11", "same-cycle no release", g_rv, 0);
        expect_frame("R11", 3, 51, 0, 7);
        expect_empty("R11", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_uc_order();
        t_priority();
        t_limit();
        t_global();
        t_mcast();
        t_alternate();
        t_shared();
        t_mc_full();
        t_bypass();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule